// File: doc/BRIEF.md
# Test Mode Entry Controller

This block decides whether a large chip enters one of four board-level test modes. While reset is held low it samples a 32-bit configuration bus on every clock edge. The first edge after reset is released freezes that sample as the strap word. Bits 3 to 0 of the strap word choose between the test modes: output three-state, NAND-tree connectivity, PLL bypass and clock output. A mode is entered only when the active-low test pin is driven low after reset has ended. Once a mode is entered, it stays until reset is asserted while the test pin is released.

In three-state mode the block counts clocks from entry and then drops a global output-enable. Pad drivers elsewhere use that enable. The count defaults to six and a parameter can shorten it. The frozen strap word is also presented unchanged as a read-only status word. The pad drivers, the NAND-tree chain and the PLL are outside this block.

Top module: `test_entry_ctrl`

## Requirements
- R1: On every rising clock edge where `rst_n` is low, the strap word captures `strap_bus`. `strap_status` then equals the bus value sampled at the last such edge.
- R2: On rising edges where `rst_n` is high, the strap word does not change, whatever `strap_bus` does. All 32 bits are returned unchanged on `strap_status`, including bits 31 to 4.
- R3: Mode entry happens on a rising edge where `rst_n` is high, `test_n` is low, no mode is active and strap bits 3:0 are not all zero. At that edge `mode_sel` takes a one-hot value. Bit 0 is three-state, bit 1 is NAND-tree, bit 2 is PLL bypass and bit 3 is clock output.
- R4: When several of strap bits 3:0 are set, the lowest-numbered set bit selects the mode.
- R5: When strap bits 3:0 are all zero, asserting `test_n` has no effect: `mode_sel` stays 0 and `out_en` stays 1.
- R6: Once a mode is active and `rst_n` is high, `mode_sel` holds its value. Releasing `test_n` does not change it.
- R7: A rising edge with `rst_n` low and `test_n` high clears `mode_sel` to 0 and returns `out_en` to 1. A rising edge with `rst_n` low and `test_n` low keeps the active mode.
- R8: In three-state mode, `out_en` stays 1 for the first TRI_CLKS rising edges after the entry edge. It drops to 0 on edge TRI_CLKS after entry, where TRI_CLKS is at most 6 and defaults to 6. It then stays 0 while the mode lasts. In every other mode, `out_en` stays 1.
- R9: After reset is held with `test_n` high, `mode_sel` is 0 and `out_en` is 1.
- R10: `mode_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| test_n | input | 1 | Active-low test request pin |
| strap_bus | input | 32 | Shared bus carrying configuration straps |
| mode_sel | output | 4 | One-hot active test mode (0 three-state, 1 NAND-tree, 2 PLL bypass, 3 clock output) |
| out_en | output | 1 | Global output-enable, low once the three-state delay has elapsed |
| strap_status | output | 32 | Frozen strap word, read-only |

## Verification
Mode selection is tried with single strap bits for three-state, PLL bypass and clock output, with a pair of bits to check that the lowest bit wins, and with straps whose low nibble is zero but whose upper bits are all ones. These cases separate correct decoding from priority errors and show that the upper bits never start a mode. The strap bus is changed after reset is released, which shows whether the word is truly frozen. Reset is also applied once with the test pin held low and once with it released, which separates holding the mode from leaving it. In three-state mode, `out_en` is sampled on every edge from entry until it falls, so a count that is off by one in either direction is caught.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

  localparam int MODE_N    = 4;
  localparam int TRI_MAX   = 6;

  typedef enum logic [1:0] {
    MD_TRISTATE = 2'd0,
    MD_NANDTREE = 2'd1,
    MD_PLLBYP   = 2'd2,
    MD_CLKOUT   = 2'd3
  } tmode_e;

  // Lowest set request bit wins; result is one-hot or zero.
  function automatic logic [MODE_N-1:0] pick_lowest(input logic [MODE_N-1:0] req);
    logic [MODE_N-1:0] res;
    res = '0;
    for (int i = MODE_N - 1; i >= 0; i--) begin
      if (req[i]) begin
        res    = '0;
        res[i] = 1'b1;
      end
    end
    return res;
  endfunction

  // Saturating increment used by the three-state delay counter.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] word_o,
  output logic             capture_evt_o
);

  logic [WIDTH-1:0] word_q;

  // Capture happens on every edge while reset is low; frozen otherwise.
  assign capture_evt_o = !rst_n;

  always_ff @(posedge clk) begin
    if (capture_evt_o) begin
      word_q <= bus_i;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import tmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_n,
  input  logic [MODE_N-1:0] req_i,
  output logic [MODE_N-1:0] mode_o,
  output logic              entry_evt_o,
  output logic              exit_evt_o
);

  logic [MODE_N-1:0] mode_q;
  logic              idle;

  assign idle        = (mode_q == '0);
  assign entry_evt_o = rst_n && !test_n && idle && (|req_i);
  assign exit_evt_o  = !rst_n && test_n;

  always_ff @(posedge clk) begin
    if (exit_evt_o) begin
      mode_q <= '0;
    end else if (entry_evt_o) begin
      mode_q <= pick_lowest(req_i);
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/tristate_timer.sv
module tristate_timer
  import tmode_pkg::*;
#(
  parameter int TRI_CLKS = TRI_MAX
) (
  input  logic clk,
  input  logic active_i,
  output logic oe_o,
  output logic done_o
);

  localparam int CW = $clog2(TRI_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TRI_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!active_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= CW'(sat_inc(int'(cnt_q), TRI_CLKS));
    end
  end

  assign done_o = active_i && (cnt_q == LIMIT);
  assign oe_o   = !done_o;

endmodule

// File: rtl/test_entry_ctrl.sv
module test_entry_ctrl
  import tmode_pkg::*;
#(
  parameter int STRAP_W  = 32,
  parameter int TRI_CLKS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_n,
  input  logic [STRAP_W-1:0] strap_bus,
  output logic [MODE_N-1:0]  mode_sel,
  output logic               out_en,
  output logic [STRAP_W-1:0] strap_status
);

  logic [STRAP_W-1:0] strap_word;
  logic               capture_evt;
  logic               entry_evt;
  logic               exit_evt;
  logic               tri_done;
  logic [MODE_N-1:0]  mode_w;

  strap_latch #(.WIDTH(STRAP_W)) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_i         (strap_bus),
    .word_o        (strap_word),
    .capture_evt_o (capture_evt)
  );

  mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_n      (test_n),
    .req_i       (strap_word[MODE_N-1:0]),
    .mode_o      (mode_w),
    .entry_evt_o (entry_evt),
    .exit_evt_o  (exit_evt)
  );

  tristate_timer #(.TRI_CLKS(TRI_CLKS)) u_timer (
    .clk      (clk),
    .active_i (mode_w[MD_TRISTATE]),
    .oe_o     (out_en),
    .done_o   (tri_done)
  );

  // Status word: every latched bit is returned as captured.
  for (genvar g = 0; g < STRAP_W; g++) begin : g_status
    assign strap_status[g] = strap_word[g];
  end

  assign mode_sel = mode_w;

endmodule

// File: rtl/test_entry_ctrl_chk.sv
module test_entry_ctrl_chk #(
  parameter int TRI_CLKS = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        test_n,
  input logic [31:0] strap_bus,
  input logic [3:0]  mode_sel,
  input logic        out_en,
  input logic [31:0] strap_status,
  input logic        entry_evt
);

  logic        past_ok = 1'b0;
  int unsigned tri_age = 0;

  always_ff @(posedge clk) begin
    past_ok <= 1'b1;
    if (!mode_sel[0]) tri_age <= 0;
    else if (tri_age < TRI_CLKS) tri_age <= tri_age + 1;
  end

  a_r1_capture: assert property (@(posedge clk)
    (past_ok && !rst_n) |=> strap_status == $past(strap_bus));

  a_r2_frozen: assert property (@(posedge clk)
    (past_ok && rst_n) |=> $stable(strap_status));

  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && entry_evt) |=>
      mode_sel == ($past(strap_status[3:0]) & (~$past(strap_status[3:0]) + 4'd1)));

  a_r5_no_straps: assert property (@(posedge clk)
    (past_ok && rst_n && strap_status[3:0] == 4'd0 && mode_sel == 4'd0) |=> mode_sel == 4'd0);

  a_r6_hold: assert property (@(posedge clk)
    (past_ok && rst_n && mode_sel != 4'd0) |=> $stable(mode_sel));

  a_r7_exit: assert property (@(posedge clk)
    (past_ok && !rst_n && test_n) |=> (mode_sel == 4'd0 && out_en));

  a_r7_keep: assert property (@(posedge clk)
    (past_ok && !rst_n && !test_n) |=> $stable(mode_sel));

  a_r8_window: assert property (@(posedge clk)
    (past_ok && mode_sel[0]) |-> out_en == (tri_age < TRI_CLKS));

  a_r8_only_tristate: assert property (@(posedge clk)
    (past_ok && !out_en) |-> mode_sel[0]);

  a_r10_onehot: assert property (@(posedge clk)
    past_ok |-> $onehot0(mode_sel));

endmodule

bind test_entry_ctrl test_entry_ctrl_chk #(.TRI_CLKS(TRI_CLKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .test_n       (test_n),
  .strap_bus    (strap_bus),
  .mode_sel     (mode_sel),
  .out_en       (out_en),
  .strap_status (strap_status),
  .entry_evt    (entry_evt)
);

// File: tb/sim_test_entry_ctrl.sv
module sim_test_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TRI        = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_n = 1'b1;
  logic [31:0] strap_bus = 32'h0;
  logic [3:0]  mode_sel;
  logic        out_en;
  logic [31:0] strap_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  test_entry_ctrl #(.STRAP_W(32), .TRI_CLKS(TRI)) u0 (
    .clk(clk), .rst_n(rst_n), .test_n(test_n), .strap_bus(strap_bus),
    .mode_sel(mode_sel), .out_en(out_en), .strap_status(strap_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Hold reset, finish with the wanted strap value, release reset.
  task automatic apply_reset(input logic [31:0] straps, input logic tst);
    @(negedge clk); rst_n = 1'b0; test_n = tst; strap_bus = ~straps;
    tick(); tick();
    @(negedge clk); strap_bus = straps;
    tick();
    chk("R1 capture", strap_status, straps);
    @(negedge clk); rst_n = 1'b1; strap_bus = straps ^ 32'h5A5A_A5A5;
  endtask

  task automatic t_reset_state();
    apply_reset(32'h0000_0000, 1'b1);
    tick();
    chk("R9 mode_sel", {28'h0, mode_sel}, 32'h0);
    chk("R9 out_en", {31'h0, out_en}, 32'h1);
  endtask

  task automatic t_tristate();
    apply_reset(32'hDEAD_BEE1, 1'b1);
    tick(); tick();
    chk("R2 frozen", strap_status, 32'hDEAD_BEE1);
    @(negedge clk); test_n = 1'b0;
    tick();
    chk("R3 tristate entry", {28'h0, mode_sel}, 32'h1);
    chk("R8 oe at entry", {31'h0, out_en}, 32'h1);
    for (int k = 1; k <= TRI; k++) begin
      tick();
      chk($sformatf("R8 oe edge %0d", k), {31'h0, out_en}, (k < TRI) ? 32'h1 : 32'h0);
    end
    @(negedge clk); test_n = 1'b1;
    tick(); tick(); tick();
    chk("R6 mode held", {28'h0, mode_sel}, 32'h1);
    chk("R8 oe stays low", {31'h0, out_en}, 32'h0);
    @(negedge clk); rst_n = 1'b0;
    tick();
    chk("R7 exit mode", {28'h0, mode_sel}, 32'h0);
    chk("R7 exit oe", {31'h0, out_en}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_mode(input logic [31:0] straps, input logic [3:0] exp_mode, input string req);
    apply_reset(straps, 1'b1);
    @(negedge clk); test_n = 1'b0;
    tick();
    chk(req, {28'h0, mode_sel}, {28'h0, exp_mode});
    for (int k = 0; k < TRI + 2; k++) tick();
    chk({req, " R8 oe high"}, {31'h0, out_en}, 32'h1);
    @(negedge clk); test_n = 1'b1;
  endtask

  task automatic t_no_straps();
    apply_reset(32'hFFFF_FFF0, 1'b1);
    @(negedge clk); test_n = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk("R5 no mode", {28'h0, mode_sel}, 32'h0);
    chk("R5 oe high", {31'h0, out_en}, 32'h1);
    chk("R2 upper bits", strap_status, 32'hFFFF_FFF0);
    @(negedge clk); test_n = 1'b1;
  endtask

  task automatic t_reset_with_test();
    apply_reset(32'h0000_0002, 1'b1);
    @(negedge clk); test_n = 1'b0;
    tick();
    chk("R3 nand entry", {28'h0, mode_sel}, 32'h2);
    @(negedge clk); rst_n = 1'b0; strap_bus = 32'h0000_0001;
    tick(); tick();
    chk("R7 kept in reset", {28'h0, mode_sel}, 32'h2);
    chk("R1 recapture", strap_status, 32'h0000_0001);
    @(negedge clk); rst_n = 1'b1; test_n = 1'b1;
    tick();
    chk("R6 kept after release", {28'h0, mode_sel}, 32'h2);
  endtask

  initial begin
    t_reset_state();
    t_tristate();
    t_mode(32'h1234_5676, 4'b0010, "R4 lowest wins");
    t_mode(32'h0000_0008, 4'b1000, "R3 clock output");
    t_mode(32'h0000_0004, 4'b0100, "R3 pll bypass");
    t_no_straps();
    t_reset_with_test();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

endmodule